// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

The unit takes two 32-bit operand words, splits each into packed lanes, and applies one arithmetic operation to every lane in parallel. Either four 8-bit lanes or two 16-bit lanes can be used. The available operations are:

- add and subtract, signed or unsigned, with saturation or with wrap-around;
- halving add and halving subtract, each with an optional round-up;
- absolute value.

The packed result is returned together with a copy of a 32-bit control word. In that copy, a sticky overflow bit is set whenever any lane of an add, a subtract or an absolute value goes out of range.

The caller presents the operands, the mode inputs and the current control word, and pulses `in_valid`. One clock later the unit registers the packed result and the updated control word and raises `out_valid` for one cycle. Between requests the outputs hold their last values. Lanes never exchange carries.

Top module: `simd_addsub`

## Requirements
- R1: Lane i occupies bits [W*(i+1)-1 : W*i], so lane 0 is at the least significant end. `lane_fmt`=0 selects four lanes of W=8, and `lane_fmt`=1 selects two lanes of W=16. No carry or borrow passes between lanes.
- R2: `op_sel` codes are 0 add, 1 subtract, 2 halving add, 3 halving subtract and 4 absolute value; codes 5 to 7 act as add. For add and subtract with `sat_en`=0, each lane result wraps to W bits. A lane whose true result lies outside its range still counts as overflowed.
- R3: The signed lane range is -2^(W-1) to 2^(W-1)-1 and the unsigned range is 0 to 2^W-1. With `is_signed`=1 operands are sign-extended, and otherwise they are zero-extended. With `sat_en`=1, add and subtract clamp an out-of-range lane to the nearest range limit and count it as overflowed.
- R4: A halving add or subtract returns floor((a±b)/2), computed at full precision in the chosen signedness.
- R5: With `rnd_en`=1, a halving operation adds 1 to the full-precision sum or difference before halving. `rnd_en` has no effect on other operations.
- R6: Absolute value always treats lanes as signed and ignores `is_signed` and `sat_en`. The most negative lane value becomes the most positive value and counts as overflowed. Other negative values are negated, and non-negative values pass unchanged.
- R7: `ctl_out` equals `ctl_in` with bit 20 additionally set when any lane of an add, subtract or absolute value overflowed. All other bits are copied unchanged, and a bit 20 that is already 1 stays 1.
- R8: Halving operations return `ctl_in` unchanged on `ctl_out`.
- R9: `result` and `ctl_out` are registered on the clock edge that samples `in_valid`=1, and `out_valid` is 1 for exactly that following cycle. Without `in_valid` the outputs hold. Reset clears `result`, `ctl_out` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand (unused by absolute value) |
| lane_fmt | input | 1 | 0: four 8-bit lanes, 1: two 16-bit lanes |
| is_signed | input | 1 | Signed lane interpretation |
| op_sel | input | 3 | Operation code (see R2) |
| sat_en | input | 1 | Saturate add/subtract |
| rnd_en | input | 1 | Round halving operations |
| ctl_in | input | 32 | Current control word |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Packed result |
| ctl_out | output | 32 | Updated control word |

## Verification
The hardest cases to reach are those where lanes sit at opposite ends of their range at the same time. One example is a lane wrapping while its neighbour must not receive the carry. Another is a most-negative lane in absolute value or a negative odd sum under rounding, in both byte and halfword packing. Hand-built words place those extremes in chosen lanes together, with control words that have bit 20 both clear and already set. A pseudo-random sweep over every operation, format and mode is then compared against an integer lane model in the bench.

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16,
  parameter int OVF_BIT  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              lane_fmt,
  input  logic              is_signed,
  input  logic [2:0]        op_sel,
  input  logic              sat_en,
  input  logic              rnd_en,
  input  logic [WORD_W-1:0] ctl_in,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic [WORD_W-1:0] ctl_out
);

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_SUB  = 3'd1;
  localparam logic [2:0] OP_HADD = 3'd2;
  localparam logic [2:0] OP_HSUB = 3'd3;
  localparam logic [2:0] OP_ABS  = 3'd4;
  localparam logic [WORD_W-1:0] OVF_MASK = WORD_W'(1) << OVF_BIT;

  logic [WORD_W-1:0] fmt_res [2];
  logic [1:0]        fmt_ovf;
  logic              is_sub;

  assign is_sub = (op_sel == OP_SUB) || (op_sel == OP_HSUB);

  for (genvar f = 0; f < 2; f++) begin : g_fmt
    localparam int W  = (f == 0) ? NARROW_W : WIDE_W;
    localparam int NL = WORD_W / W;
    localparam int EW = W + 2;
    localparam logic signed [EW-1:0] SMAX = EW'((1 << (W - 1)) - 1);
    localparam logic signed [EW-1:0] SMIN = -SMAX - EW'(1);
    localparam logic signed [EW-1:0] UMAX = EW'((1 << W) - 1);

    logic [NL-1:0]     lane_ovf;
    logic [WORD_W-1:0] packed_res;

    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [W-1:0]           a_l, b_l, r_l;
      logic signed [EW-1:0]   ax, bx, full, hv, hi, lo;
      logic                   ovf_l;
      logic                   lane_unused;

      assign a_l  = op_a[W*i +: W];
      assign b_l  = op_b[W*i +: W];
      assign ax   = {{2{is_signed & a_l[W-1]}}, a_l};
      assign bx   = {{2{is_signed & b_l[W-1]}}, b_l};
      assign full = is_sub ? (ax - bx) : (ax + bx);
      assign hv   = full + {{(EW-1){1'b0}}, rnd_en};
      assign hi   = is_signed ? SMAX : UMAX;
      assign lo   = is_signed ? SMIN : '0;
      assign lane_unused = ^{hv[EW-1], hv[0]};

      always_comb begin
        ovf_l = 1'b0;
        r_l   = full[W-1:0];
        case (op_sel)
          OP_HADD, OP_HSUB: r_l = hv[W:1];
          OP_ABS: begin
            if (a_l == {1'b1, {(W-1){1'b0}}}) begin
              r_l   = SMAX[W-1:0];
              ovf_l = 1'b1;
            end else if (a_l[W-1]) begin
              r_l = ~a_l + W'(1);
            end else begin
              r_l = a_l;
            end
          end
          default: begin
            if (full > hi) begin
              ovf_l = 1'b1;
              if (sat_en) r_l = hi[W-1:0];
            end else if (full < lo) begin
              ovf_l = 1'b1;
              if (sat_en) r_l = lo[W-1:0];
            end
          end
        endcase
      end

      assign packed_res[W*i +: W] = r_l;
      assign lane_ovf[i]          = ovf_l;
    end

    assign fmt_res[f] = packed_res;
    assign fmt_ovf[f] = |lane_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ctl_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= fmt_res[lane_fmt];
        ctl_out <= ctl_in | (fmt_ovf[lane_fmt] ? OVF_MASK : '0);
      end
    end
  end

endmodule

module simd_addsub_chk #(
  parameter int WORD_W  = 32,
  parameter int OVF_BIT = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] op_a,
  input logic              lane_fmt,
  input logic              is_signed,
  input logic [2:0]        op_sel,
  input logic              sat_en,
  input logic [WORD_W-1:0] ctl_in,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic [WORD_W-1:0] ctl_out
);

  localparam logic [WORD_W-1:0] KEEP = ~(WORD_W'(1) << OVF_BIT);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(ctl_out)));

  // R7
  ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((ctl_out ^ $past(ctl_in)) & KEEP) == '0));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctl_in[OVF_BIT]) |=> ctl_out[OVF_BIT]);

  // R8
  half_noctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == 3'd2 || op_sel == 3'd3)) |=> (ctl_out == $past(ctl_in)));

  // R3
  usat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lane_fmt && !is_signed && sat_en && op_sel == 3'd0)
      |=> (result[7:0] >= $past(op_a[7:0])));

endmodule

bind simd_addsub simd_addsub_chk #(.WORD_W(WORD_W), .OVF_BIT(OVF_BIT)) u_chk (.*);

// File: tb/simd_addsub_bench.sv
module simd_addsub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, ctl_in = '0;
  logic        lane_fmt = 1'b0, is_signed = 1'b0, sat_en = 1'b0, rnd_en = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        out_valid;
  logic [31:0] result, ctl_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_addsub u_simd_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .lane_fmt(lane_fmt), .is_signed(is_signed), .op_sel(op_sel), .sat_en(sat_en),
    .rnd_en(rnd_en), .ctl_in(ctl_in), .out_valid(out_valid), .result(result),
    .ctl_out(ctl_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic fmt, input logic sgn, input logic [2:0] op,
                                input logic sat, input logic rnd, input logic [31:0] ci,
                                output logic [31:0] r, output logic [31:0] co);
    int w = fmt ? 16 : 8;
    int n = 32 / w;
    longint m = (longint'(1) << w) - 1;
    longint half = longint'(1) << (w - 1);
    bit ov = 0;
    r = '0;
    for (int i = 0; i < n; i++) begin
      longint ua = longint'((a >> (i * w))) & m;
      longint ub = longint'((b >> (i * w))) & m;
      bit s = (op == 3'd4) ? 1'b1 : sgn;
      longint x = (s && ua >= half) ? ua - (m + 1) : ua;
      longint y = (s && ub >= half) ? ub - (m + 1) : ub;
      longint hi = s ? half - 1 : m;
      longint lo = s ? -half : 0;
      longint v;
      case (op)
        3'd1: v = x - y;
        3'd2: v = (x + y + longint'(rnd)) >>> 1;
        3'd3: v = (x - y + longint'(rnd)) >>> 1;
        3'd4: begin
          if (x == lo) begin v = hi; ov = 1; end
          else v = (x < 0) ? -x : x;
        end
        default: v = x + y;
      endcase
      if (op != 3'd2 && op != 3'd3 && op != 3'd4) begin
        if (v > hi) begin ov = 1; if (sat) v = hi; end
        else if (v < lo) begin ov = 1; if (sat) v = lo; end
      end
      r = r | (32'(v & m) << (i * w));
    end
    co = ci | (ov ? 32'h0010_0000 : 32'h0);
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic fmt,
                        input logic sgn, input logic [2:0] op, input logic sat,
                        input logic rnd, input logic [31:0] ci,
                        output logic [31:0] r, output logic [31:0] co, output logic v);
    @(negedge clk);
    op_a = a; op_b = b; lane_fmt = fmt; is_signed = sgn; op_sel = op;
    sat_en = sat; rnd_en = rnd; ctl_in = ci; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = result; co = ctl_out; v = out_valid;
  endtask

  task automatic expect_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input logic fmt, input logic sgn, input logic [2:0] op,
                           input logic sat, input logic rnd, input logic [31:0] ci,
                           input logic [31:0] er, input logic [31:0] ec);
    logic [31:0] r, co;
    logic v;
    run_op(a, b, fmt, sgn, op, sat, rnd, ci, r, co, v);
    chk({tag, " result"}, r, er);
    chk({tag, " ctl"}, co, ec);
    chk({tag, " valid"}, {31'b0, v}, 32'h1);
  endtask

  task automatic t_reset();
    chk("R9 reset valid", {31'b0, out_valid}, 32'h0);
    chk("R9 reset result", result, 32'h0);
    chk("R9 reset ctl", ctl_out, 32'h0);
  endtask

  task automatic t_layout();
    expect_op("R1 byte lanes", 32'h00FF_0102, 32'h0001_0304, 0, 0, 3'd0, 0, 0,
              32'h0, 32'h0000_0406, 32'h0010_0000);
    expect_op("R1 half lanes", 32'h00FF_0102, 32'h0001_0304, 1, 0, 3'd0, 0, 0,
              32'h0, 32'h0100_0406, 32'h0);
  endtask

  task automatic t_wrap();
    expect_op("R2 signed wrap add", 32'h0000_007F, 32'h0000_0001, 0, 1, 3'd0, 0, 0,
              32'h0000_0001, 32'h0000_0080, 32'h0010_0001);
    expect_op("R2 unsigned wrap sub", 32'h0000_0000, 32'h0000_0001, 1, 0, 3'd1, 0, 0,
              32'h0, 32'h0000_FFFF, 32'h0010_0000);
    expect_op("R2 code 5 as add", 32'h0102_0304, 32'h0101_0101, 0, 0, 3'd5, 0, 0,
              32'h0, 32'h0203_0405, 32'h0);
  endtask

  task automatic t_sat();
    expect_op("R3 signed sat add", 32'h7F7F_7F7F, 32'h0100_0101, 0, 1, 3'd0, 1, 0,
              32'h0, 32'h7F7F_7F7F, 32'h0010_0000);
    expect_op("R3 signed sat sub", 32'h8000_0005, 32'h0001_0006, 1, 1, 3'd1, 1, 0,
              32'h0, 32'h8000_FFFF, 32'h0010_0000);
    expect_op("R3 unsigned sat", 32'hFF00_10F0, 32'h0101_0120, 0, 0, 3'd0, 1, 0,
              32'h0, 32'hFF01_11FF, 32'h0010_0000);
    expect_op("R3 unsigned sat sub", 32'h0010_0005, 32'h0020_0003, 1, 0, 3'd1, 1, 0,
              32'h0, 32'h0000_0002, 32'h0010_0000);
  endtask

  task automatic t_half();
    expect_op("R4 signed halving add", 32'h00FD_037F, 32'h0000_007F, 0, 1, 3'd2, 0, 0,
              32'hFFEF_FFFF, 32'h00FE_017F, 32'hFFEF_FFFF);
    expect_op("R4 unsigned halving add", 32'h0000_FFFF, 32'h0000_FFFF, 1, 0, 3'd2, 0, 0,
              32'h0, 32'h0000_FFFF, 32'h0);
    expect_op("R5 rounded halving add", 32'h00FD_037F, 32'h0000_007F, 0, 1, 3'd2, 0, 1,
              32'h0, 32'h00FF_027F, 32'h0);
    expect_op("R8 halving sub keeps ctl", 32'h0000_0080, 32'h0000_007F, 0, 1, 3'd3, 1, 0,
              32'h1234_5678, 32'h0000_0080, 32'h1234_5678);
  endtask

  task automatic t_abs();
    expect_op("R6 byte abs min", 32'h80FF_0500, 32'h0, 0, 0, 3'd4, 0, 0,
              32'h0, 32'h7F01_0500, 32'h0010_0000);
    expect_op("R6 half abs min", 32'h8000_FFFE, 32'h0, 1, 0, 3'd4, 1, 0,
              32'h0, 32'h7FFF_0002, 32'h0010_0000);
    expect_op("R6 abs no overflow", 32'h7F00_FF01, 32'h0, 0, 1, 3'd4, 0, 0,
              32'h0, 32'h7F00_0101, 32'h0);
  endtask

  task automatic t_ctl();
    expect_op("R7 sticky kept", 32'h0000_0001, 32'h0000_0001, 0, 0, 3'd0, 0, 0,
              32'h0010_0000, 32'h0000_0002, 32'h0010_0000);
    expect_op("R7 other bits kept", 32'h0000_00FF, 32'h0000_0001, 0, 0, 3'd0, 1, 0,
              32'hA5A5_A5A5, 32'h0000_00FF, 32'hA5B5_A5A5);
  endtask

  task automatic t_hold();
    logic [31:0] r, co;
    logic v;
    run_op(32'h1111_2222, 32'h0101_0101, 0, 0, 3'd0, 0, 0, 32'h0000_0F00, r, co, v);
    @(negedge clk);
    op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; ctl_in = 32'h0;
    @(negedge clk);
    chk("R9 idle valid low", {31'b0, out_valid}, 32'h0);
    chk("R9 result held", result, 32'h1212_2323);
    chk("R9 ctl held", ctl_out, 32'h0000_0F00);
  endtask

  task automatic t_sweep();
    logic [31:0] s = 32'hC0FF_EE01;
    string tags [5] = '{"R2 sweep add", "R2 sweep sub", "R4 sweep hadd", "R5 sweep hsub", "R6 sweep abs"};
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b, ci, er, ec, r, co;
      logic v;
      logic [2:0] op;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5; a = s;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5; b = s;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5; ci = s;
      op = 3'(k % 5);
      if (k % 7 == 0) a[7:0] = 8'h80;
      if (k % 11 == 0) a[31:16] = 16'h8000;
      model(a, b, s[3], s[4], op, s[5], s[6], ci, er, ec);
      run_op(a, b, s[3], s[4], op, s[5], s[6], ci, r, co, v);
      chk(tags[k % 5], r, er);
      chk(k % 5 >= 2 && k % 5 <= 3 ? "R8 sweep ctl" : "R7 sweep ctl", co, ec);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_layout();
    t_wrap();
    t_sat();
    t_half();
    t_abs();
    t_ctl();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule